// File: doc/BRIEF.md
# High/Low Counted Clock Divider

This block divides a free-running reference clock by an integer ratio. Each output period is built from two counted phases: a high phase and a low phase. Each phase length is held in a narrow field. An odd-ratio flag stretches the high phase by half a reference cycle, so odd ratios still give an even duty cycle. A no-count flag routes the reference clock straight to the output and parks the counters.

The four settings come from one of two places. They can be worked out from a requested ratio, or taken field by field from direct inputs. The block samples whichever source is selected only at the end of a complete output period. A setting that changes partway through a period therefore never cuts a pulse short. The block sits wherever a derived clock of adjustable rate is needed and software or a controller sets the rate.

Top module: `clkdiv_hl_top`

## Requirements
- R1: While `rst_n` is low, `clk_o` is low. The first output period starts at the first rising reference edge after reset is released.
- R2: In ratio mode (`use_fields_i`=0), a ratio N from 2 to 128 gives a high phase of floor(N/2) reference cycles and a low phase of N-floor(N/2) cycles. The output period is N reference cycles and starts with the high phase.
- R3: For an odd ratio, the odd flag is set. The output then stays high for an extra half reference cycle, until the falling reference edge, so the high and low times are each N/2 cycles.
- R4: A ratio of 1 or 0 selects no-count mode. In that mode `clk_o` follows `clk_ref` and the counters stay idle.
- R5: In ratio mode, any ratio above 128 is treated as 128. A high or low length of 64 is held in its 6-bit field as the value 0.
- R6: In field mode (`use_fields_i`=1), `hi_i`, `lo_i`, `odd_i` and `byp_i` are used as given. A field value of 0 stands for 64 cycles.
- R7: The selected settings are sampled only on the last reference cycle of an output period. Input changes during a period have no effect on that period.
- R8: Leaving no-count mode starts a full divided period, high phase first, at the next rising reference edge.
- R9: The cycle counter always stays below the length of the active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_fields_i | input | 1 | 1: take the direct fields; 0: derive the fields from `ratio_i` |
| ratio_i | input | 8 | Requested division ratio |
| hi_i | input | 6 | Direct high-phase length (0 means 64) |
| lo_i | input | 6 | Direct low-phase length (0 means 64) |
| odd_i | input | 1 | Direct half-cycle high extension flag |
| byp_i | input | 1 | Direct no-count flag |
| clk_o | output | 1 | Divided clock |

## Verification
The bench builds the block with its default parameters: 6-bit phase fields and an 8-bit ratio input. With an 8-bit ratio, values above the 128 cap (such as 200) can be driven, which exercises the clamp. The 6-bit field makes ratio 128 and a direct zero field use the 0-means-64 encoding. A reference model in the bench predicts the output level one quarter cycle after every reference edge of either polarity. This is how the half-cycle stretch of odd ratios and the pass-through of no-count mode are both checked.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  localparam int DIV_FIELD_W = 6;
  localparam int FIELD_SPAN  = 2 ** DIV_FIELD_W;
  localparam int MAX_RATIO   = 2 * FIELD_SPAN;

  typedef struct packed {
    logic [DIV_FIELD_W-1:0] hi;
    logic [DIV_FIELD_W-1:0] lo;
    logic                   odd;
    logic                   byp;
  } div_cfg_t;

  // length in reference cycles that a phase field stands for
  function automatic int unsigned field_len(input logic [DIV_FIELD_W-1:0] f);
    if (f == '0) return FIELD_SPAN;
    return int'(f);
  endfunction

  // derive the phase settings from a requested ratio
  function automatic div_cfg_t split_ratio(input int unsigned n_in);
    div_cfg_t    c;
    int unsigned n;
    int unsigned h;
    int unsigned l;
    n = n_in;
    c = '0;
    if (n <= 1) begin
      c.hi  = DIV_FIELD_W'(1);
      c.lo  = DIV_FIELD_W'(1);
      c.byp = 1'b1;
    end else begin
      if (n > MAX_RATIO) n = MAX_RATIO;
      h     = n / 2;
      l     = n - h;
      c.hi  = DIV_FIELD_W'(h);
      c.lo  = DIV_FIELD_W'(l);
      c.odd = n[0];
      c.byp = 1'b0;
    end
    return c;
  endfunction

endpackage

// File: rtl/clkdiv_cfg_sel.sv
`timescale 1ns/1ps
module clkdiv_cfg_sel
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               use_fields,
  input  logic [RATIO_W-1:0] ratio,
  input  div_cfg_t           fields,
  output div_cfg_t           cfg
);

  div_cfg_t from_ratio;

  always_comb begin
    from_ratio = split_ratio(int'(ratio));
    cfg        = use_fields ? fields : from_ratio;
  end

  // R5
  ratio_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_fields && int'(ratio) > MAX_RATIO)
      |-> (!cfg.byp && (field_len(cfg.hi) + field_len(cfg.lo) == MAX_RATIO)));

endmodule

// File: rtl/clkdiv_period_ctr.sv
`timescale 1ns/1ps
module clkdiv_period_ctr
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  div_cfg_t cfg_next,
  output logic     out_pos,
  output logic     act_odd,
  output logic     act_byp,
  output logic     boundary
);

  localparam int CNT_W = DIV_FIELD_W + 2;

  div_cfg_t        act;
  logic [CNT_W-1:0] cnt;
  int unsigned     plen;
  int unsigned     hi_len;
  int unsigned     cnt_nxt;

  always_comb begin
    hi_len   = field_len(act.hi);
    plen     = hi_len + field_len(act.lo);
    cnt_nxt  = int'(cnt) + 1;
    boundary = act.byp || (int'(cnt) == plen - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= '{hi: DIV_FIELD_W'(1), lo: DIV_FIELD_W'(1), odd: 1'b0, byp: 1'b0};
      cnt     <= CNT_W'(1);
      out_pos <= 1'b0;
    end else if (boundary) begin
      act     <= cfg_next;
      cnt     <= '0;
      out_pos <= !cfg_next.byp;
    end else begin
      cnt     <= CNT_W'(cnt_nxt);
      out_pos <= (cnt_nxt < hi_len);
    end
  end

  assign act_odd = act.odd;
  assign act_byp = act.byp;

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < plen);

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act));

  // R4
  byp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.byp |-> (cnt == '0 && !out_pos));

  // R2
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_pos) |-> (cnt == '0));

endmodule

// File: rtl/clkdiv_half_ext.sv
`timescale 1ns/1ps
module clkdiv_half_ext (
  input  logic clk,
  input  logic rst_n,
  input  logic out_pos,
  input  logic act_odd,
  input  logic act_byp,
  output logic clk_o
);

  logic out_neg;

  // retimed copy, half a reference cycle behind the counted phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) out_neg <= 1'b0;
    else        out_neg <= out_pos;
  end

  assign clk_o = act_byp ? clk : (out_pos | (act_odd & out_neg));

endmodule

// File: rtl/clkdiv_hl_top.sv
`timescale 1ns/1ps
module clkdiv_hl_top
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic                   clk_ref,
  input  logic                   rst_n,
  input  logic                   use_fields_i,
  input  logic [RATIO_W-1:0]     ratio_i,
  input  logic [DIV_FIELD_W-1:0] hi_i,
  input  logic [DIV_FIELD_W-1:0] lo_i,
  input  logic                   odd_i,
  input  logic                   byp_i,
  output logic                   clk_o
);

  div_cfg_t fields;
  div_cfg_t cfg_next;
  logic     out_pos;
  logic     act_odd;
  logic     act_byp;
  logic     boundary;

  assign fields = '{hi: hi_i, lo: lo_i, odd: odd_i, byp: byp_i};

  clkdiv_cfg_sel #(.RATIO_W(RATIO_W)) u_sel (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .use_fields (use_fields_i),
    .ratio      (ratio_i),
    .fields     (fields),
    .cfg        (cfg_next)
  );

  clkdiv_period_ctr u_ctr (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .cfg_next (cfg_next),
    .out_pos  (out_pos),
    .act_odd  (act_odd),
    .act_byp  (act_byp),
    .boundary (boundary)
  );

  clkdiv_half_ext u_ext (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .out_pos (out_pos),
    .act_odd (act_odd),
    .act_byp (act_byp),
    .clk_o   (clk_o)
  );

  // R8
  leave_byp_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (act_byp && boundary && !cfg_next.byp) |=> (out_pos && !act_byp));

endmodule

// File: tb/sim_clkdiv_hl_top.sv
`timescale 1ns/1ps
module sim_clkdiv_hl_top;

  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic       use_fields_i = 1'b0;
  logic [7:0] ratio_i = 8'd2;
  logic [5:0] hi_i = 6'd1;
  logic [5:0] lo_i = 6'd1;
  logic       odd_i = 1'b0;
  logic       byp_i = 1'b0;
  logic       clk_o;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // reference model state
  int m_hi = 1, m_lo = 1, m_pos = 1;
  bit m_odd = 0, m_byp = 0;

  always #4 clk_ref = ~clk_ref;

  clkdiv_hl_top u0 (
    .clk_ref(clk_ref), .rst_n(rst_n), .use_fields_i(use_fields_i),
    .ratio_i(ratio_i), .hi_i(hi_i), .lo_i(lo_i), .odd_i(odd_i),
    .byp_i(byp_i), .clk_o(clk_o)
  );

  task automatic load_model();
    int n;
    if (use_fields_i) begin
      m_hi  = (hi_i == 0) ? 64 : int'(hi_i);
      m_lo  = (lo_i == 0) ? 64 : int'(lo_i);
      m_odd = odd_i;
      m_byp = byp_i;
    end else begin
      n = int'(ratio_i);
      if (n < 2) begin
        m_byp = 1; m_odd = 0; m_hi = 1; m_lo = 1;
      end else begin
        if (n > 128) n = 128;
        m_byp = 0;
        m_hi  = n / 2;
        m_lo  = n - m_hi;
        m_odd = (n % 2) == 1;
      end
    end
  endtask

  task automatic check(input logic exp, input string ph);
    checks++;
    if (clk_o !== exp) begin
      errors++;
      $display("FAIL %s %s t=%0t actual=%b expected=%b", cur_req, ph, $time, clk_o, exp);
    end
  endtask

  task automatic tick();
    logic e;
    @(posedge clk_ref);
    if (rst_n) begin
      if (m_byp || m_pos == m_hi + m_lo - 1) begin
        load_model();
        m_pos = 0;
      end else begin
        m_pos++;
      end
    end
    #2;
    if (!rst_n)     e = 1'b0;
    else if (m_byp) e = 1'b1;
    else            e = (m_pos < m_hi) || (m_odd && m_pos == m_hi);
    check(e, "first-half");
    @(negedge clk_ref);
    #2;
    if (!rst_n)     e = 1'b0;
    else if (m_byp) e = 1'b0;
    else            e = (m_pos < m_hi);
    check(e, "second-half");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_ratio(input int n);
    use_fields_i = 1'b0;
    ratio_i      = 8'(n);
  endtask

  task automatic set_fields(input int h, input int l, input bit o, input bit b);
    use_fields_i = 1'b1;
    hi_i  = 6'(h);
    lo_i  = 6'(l);
    odd_i = o;
    byp_i = b;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    // R1: output low during reset
    cur_req = "R1";
    run(3);
    rst_n = 1'b1;
    run(6);

    // R2: even ratios
    cur_req = "R2";
    set_ratio(4);  run(14);
    set_ratio(10); run(32);
    set_ratio(2);  run(8);

    // R3: odd ratios with half-cycle stretch
    cur_req = "R3";
    set_ratio(3);  run(12);
    set_ratio(5);  run(17);
    set_ratio(11); run(35);

    // R4: no-count mode via ratio 1 and 0
    cur_req = "R4";
    set_ratio(1);  run(10);
    set_ratio(0);  run(10);

    // R8: leaving no-count mode
    cur_req = "R8";
    set_ratio(6);  run(20);
    set_ratio(1);  run(5);
    set_ratio(7);  run(22);

    // R7: change mid-period, must wait for the boundary
    cur_req = "R7";
    set_ratio(20); run(25);
    set_ratio(4);  run(3);
    set_ratio(9);  run(2);
    set_ratio(3);  run(30);

    // R5: cap at 128, 64 encoded as 0
    cur_req = "R5";
    set_ratio(128); run(260);
    set_ratio(200); run(260);
    set_ratio(255); run(140);

    // R6: direct fields
    cur_req = "R6";
    set_fields(3, 5, 1'b0, 1'b0); run(20);
    set_fields(2, 3, 1'b1, 1'b0); run(15);
    set_fields(0, 1, 1'b0, 1'b0); run(140);
    set_fields(1, 0, 1'b1, 1'b0); run(140);
    set_fields(4, 4, 1'b0, 1'b1); run(10);
    set_fields(1, 2, 1'b0, 1'b0); run(9);

    // R9: long run, counter range guarded by the design's check
    cur_req = "R9";
    set_ratio(63); run(130);

    // R1: reset again mid-period
    cur_req = "R1";
    set_ratio(9); run(4);
    @(negedge clk_ref); #1;
    rst_n = 1'b0;
    m_hi = 1; m_lo = 1; m_pos = 1; m_odd = 0; m_byp = 0;
    run(3);
    rst_n = 1'b1;
    run(20);

    finish_run();
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    finish_run();
  end

endmodule